// File: doc/BRIEF.md
# Oversampled PDM Speaker Modulator

This block turns 24-bit signed PCM samples into a single-bit pulse-density stream suitable for a digital speaker or a PDM codec input. Each accepted sample is held for a programmable number of PDM periods (zero-order-hold interpolation). Every PDM period, a second-order error-feedback delta-sigma loop with saturating integrators reduces the held value to one bit per channel. Because the integrators saturate, full-scale inputs cannot wrap them around.

The core clock runs at four times the PDM bit clock. Each PDM period is four core cycles. Both channels share one data line: each channel owns one half of the PDM clock period, and a polarity input picks which half carries left. A channel-select input enables left only, right only or both. Samples arrive on a valid/ready stream. The block asks for a new left/right pair once per oversampling frame. If no sample is offered at that moment, it keeps modulating the previous pair. A low enable parks the PDM clock and data low and clears all modulator state.

Top module: `pdm_spk_mod`

## Requirements
- R1: The oversampling code `osr_sel_i` selects 32, 64, 128 or 256 PDM periods per input sample for codes 0, 1, 2 and 3. While enabled, `smp_ready_o` is high for one core cycle every 4 × ratio core cycles, starting with the first enabled cycle.
- R2: While enabled, `pdm_clk_o` repeats the pattern high, high, low, low, one value per core cycle, starting high in the first enabled cycle.
- R3: For a constant input x held across a window of K PDM periods after a warm-up, the number of ones in a channel's slot is within 4 of K·(x + 2^23)/2^24.
- R4: With `lr_pol_i` = 0, the left channel's bit is driven while `pdm_clk_o` is high and the right channel's bit while it is low.
- R5: With `lr_pol_i` = 1, the slots are swapped: right is driven while `pdm_clk_o` is high and left while it is low.
- R6: `ch_sel_i` = 1 enables left only, 2 right only, 3 both, and 0 neither. The slot of a disabled channel is driven low.
- R7: One core cycle after `en_i` goes low, `pdm_clk_o`, `pdm_dat_o` and `smp_ready_o` are all low and stay low while `en_i` stays low.
- R8: A sample is taken only in the cycle where `smp_valid_i` and `smp_ready_o` are both high. Sample values presented in other cycles have no effect on the output.
- R9: If `smp_valid_i` is low when `smp_ready_o` is high, the previously accepted sample pair keeps being modulated.
- R10: A full-scale positive input (2^23 − 1) produces all ones after warm-up, and a full-scale negative input (−2^23) produces all zeros after warm-up. The integrators never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, 4 × PDM clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| osr_sel_i | input | 2 | Oversampling code (0..3 → 32..256) |
| ch_sel_i | input | 2 | Channel enable code (1 left, 2 right, 3 both, 0 none) |
| lr_pol_i | input | 1 | 0: left in clock-high half, 1: left in clock-low half |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Sample pair requested this cycle |
| smp_left_i | input | 24 | Left PCM sample, signed |
| smp_right_i | input | 24 | Right PCM sample, signed |
| pdm_clk_o | output | 1 | PDM bit clock |
| pdm_dat_o | output | 1 | PDM data, time-multiplexed channels |

## Verification
The modulator is driven with constant DC levels of differing sign and size, with zero, and with both full-scale extremes. The count of ones in each slot is compared with the arithmetically expected density, which shows whether the loop tracks the input level, whether slots are swapped, and whether the integrators wrap. Alternating data that changes between request cycles, and streams that stop offering samples after the first request, tell correct capture and hold apart from sampling on the wrong cycle. Each channel-select code and each oversampling code is swept, so silenced slots and request spacing are checked against their encodings.

// File: rtl/pdm_spk_pkg.sv
package pdm_spk_pkg;
  localparam int unsigned SMP_W      = 24;
  localparam int unsigned GUARD_W    = 4;
  localparam int unsigned OSR_BASE_L = 5;
  localparam int unsigned OSR_CODE_W = 2;
  localparam int unsigned TICK_W     = OSR_BASE_L + (1 << OSR_CODE_W) - 1;

  typedef enum logic [1:0] {
    CH_NONE  = 2'd0,
    CH_LEFT  = 2'd1,
    CH_RIGHT = 2'd2,
    CH_BOTH  = 2'd3
  } ch_sel_e;

  function automatic logic [TICK_W-1:0] osr_last(input logic [OSR_CODE_W-1:0] code);
    logic [TICK_W:0] n;
    n = ({{TICK_W{1'b0}}, 1'b1} << (OSR_BASE_L + code));
    return n[TICK_W-1:0] - 1'b1;
  endfunction
endpackage

// File: rtl/pdm_spk_timing.sv
module pdm_spk_timing
  import pdm_spk_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [OSR_CODE_W-1:0] osr_sel_i,
  output logic [1:0]            phase_o,
  output logic                  step_o,
  output logic                  frame_o
);
  logic [1:0]        ph_q;
  logic [TICK_W-1:0] tick_q;

  assign step_o  = run_i && (ph_q == 2'd3);
  assign frame_o = run_i && (ph_q == 2'd0) && (tick_q == '0);
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      tick_q <= '0;
    end else if (!run_i) begin
      ph_q   <= '0;
      tick_q <= '0;
    end else begin
      ph_q <= ph_q + 2'd1;
      if (step_o) begin
        if (tick_q >= osr_last(osr_sel_i)) tick_q <= '0;
        else                               tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdm_spk_dsm.sv
module pdm_spk_dsm #(
  parameter int unsigned DW = 24,
  parameter int unsigned GW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [DW-1:0] smp_i,
  output logic          bit_o
);
  localparam int unsigned IW = DW + GW;
  localparam int unsigned XW = IW + 2;
  localparam logic signed [XW-1:0] FS   = XW'(1) <<< (DW - 1);
  localparam logic signed [XW-1:0] MAXV = (XW'(1) <<< (IW - 1)) - XW'(1);
  localparam logic signed [XW-1:0] MINV = -(XW'(1) <<< (IW - 1));

  logic signed [IW-1:0] s1_q, s2_q, s1_n, s2_n;
  logic signed [XW-1:0] x_e, fb_e, s1_w, s2_w;
  logic                 bit_q;

  function automatic logic signed [IW-1:0] sat(input logic signed [XW-1:0] v);
    if (v > MAXV)      return MAXV[IW-1:0];
    else if (v < MINV) return MINV[IW-1:0];
    else               return v[IW-1:0];
  endfunction

  always_comb begin
    x_e  = {{(XW-DW){smp_i[DW-1]}}, smp_i};
    fb_e = bit_q ? FS : -FS;
    s1_w = {{2{s1_q[IW-1]}}, s1_q} + x_e - fb_e;
    s1_n = sat(s1_w);
    s2_w = {{2{s2_q[IW-1]}}, s2_q} + {{2{s1_n[IW-1]}}, s1_n} - fb_e;
    s2_n = sat(s2_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      bit_q <= 1'b0;
    end else if (clr_i) begin
      s1_q  <= '0;
      s2_q  <= '0;
      bit_q <= 1'b0;
    end else if (step_i) begin
      s1_q  <= s1_n;
      s2_q  <= s2_n;
      bit_q <= !s2_n[IW-1];
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/pdm_spk_slot.sv
module pdm_spk_slot
  import pdm_spk_pkg::*;
(
  input  logic       run_i,
  input  logic [1:0] phase_i,
  input  logic       lr_pol_i,
  input  ch_sel_e    ch_sel_i,
  input  logic       bit_l_i,
  input  logic       bit_r_i,
  output logic       pdm_clk_o,
  output logic       pdm_dat_o
);
  logic first_half, left_slot, l_act, r_act;

  always_comb begin
    first_half = !phase_i[1];
    left_slot  = first_half ^ lr_pol_i;
    l_act      = (ch_sel_i == CH_LEFT)  || (ch_sel_i == CH_BOTH);
    r_act      = (ch_sel_i == CH_RIGHT) || (ch_sel_i == CH_BOTH);
    pdm_clk_o  = run_i && first_half;
    pdm_dat_o  = run_i && (left_slot ? (bit_l_i && l_act) : (bit_r_i && r_act));
  end
endmodule

// File: rtl/pdm_spk_mod.sv
module pdm_spk_mod
  import pdm_spk_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [OSR_CODE_W-1:0] osr_sel_i,
  input  logic [1:0]            ch_sel_i,
  input  logic                  lr_pol_i,
  input  logic                  smp_valid_i,
  output logic                  smp_ready_o,
  input  logic [SMP_W-1:0]      smp_left_i,
  input  logic [SMP_W-1:0]      smp_right_i,
  output logic                  pdm_clk_o,
  output logic                  pdm_dat_o
);
  localparam int unsigned NCH = 2;

  logic             run_q;
  logic [1:0]       phase;
  logic             step, frame;
  logic [SMP_W-1:0] hold_q [NCH];
  logic [SMP_W-1:0] smp_in [NCH];
  logic [NCH-1:0]   bits;

  assign smp_in[0] = smp_left_i;
  assign smp_in[1] = smp_right_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  pdm_spk_timing u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .osr_sel_i (osr_sel_i),
    .phase_o   (phase),
    .step_o    (step),
    .frame_o   (frame)
  );

  assign smp_ready_o = frame;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    hold_q[c] <= '0;
      else if (!run_q)                hold_q[c] <= '0;
      else if (frame && smp_valid_i)  hold_q[c] <= smp_in[c];
    end

    pdm_spk_dsm #(.DW(SMP_W), .GW(GUARD_W)) u_dsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!run_q),
      .step_i (step),
      .smp_i  (hold_q[c]),
      .bit_o  (bits[c])
    );
  end

  pdm_spk_slot u_slot (
    .run_i     (run_q),
    .phase_i   (phase),
    .lr_pol_i  (lr_pol_i),
    .ch_sel_i  (ch_sel_e'(ch_sel_i)),
    .bit_l_i   (bits[0]),
    .bit_r_i   (bits[1]),
    .pdm_clk_o (pdm_clk_o),
    .pdm_dat_o (pdm_dat_o)
  );
endmodule

// File: rtl/pdm_spk_mod_chk.sv
module pdm_spk_mod_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [1:0] osr_sel_i,
  input logic [1:0] ch_sel_i,
  input logic       lr_pol_i,
  input logic       smp_ready_o,
  input logic       pdm_clk_o,
  input logic       pdm_dat_o
);
  logic        en_d, seen_q;
  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d <= 1'b0; seen_q <= 1'b0; gap_q <= '0;
    end else begin
      en_d <= en_i;
      if (!en_d) begin
        seen_q <= 1'b0; gap_q <= '0;
      end else if (smp_ready_o) begin
        seen_q <= 1'b1; gap_q <= 16'd1;
      end else begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  assert_req_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_ready_o && seen_q && en_d) |-> (gap_q == (16'd4 << (osr_sel_i + 2'd0 + 5))));

  assert_clk_high_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pdm_clk_o) && en_i) |=> pdm_clk_o);

  assert_clk_low_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pdm_clk_o) && en_i) |=> !pdm_clk_o);

  assert_no_channel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_sel_i == 2'd0) |-> !pdm_dat_o);

  assert_right_mute_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_sel_i == 2'd1 && pdm_clk_o == lr_pol_i) |-> !pdm_dat_o);

  assert_left_mute_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_sel_i == 2'd2 && pdm_clk_o != lr_pol_i) |-> !pdm_dat_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pdm_clk_o && !pdm_dat_o && !smp_ready_o));
endmodule

bind pdm_spk_mod pdm_spk_mod_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .osr_sel_i   (osr_sel_i),
  .ch_sel_i    (ch_sel_i),
  .lr_pol_i    (lr_pol_i),
  .smp_ready_o (smp_ready_o),
  .pdm_clk_o   (pdm_clk_o),
  .pdm_dat_o   (pdm_dat_o)
);

// File: tb/pdm_spk_mod_tb.sv
module pdm_spk_mod_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WARM = 64;
  localparam int  WIN  = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, pol = 1'b0, valid = 1'b0;
  logic [1:0] osr = 2'd0, chs = 2'd3;
  logic [23:0] sl = '0, sr = '0;
  logic ready, pclk, pdat;

  int n_chk = 0, n_bad = 0;
  int mode = 0;
  bit took = 0;
  logic [23:0] al, ar, bl, br;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_spk_mod u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .osr_sel_i(osr), .ch_sel_i(chs),
    .lr_pol_i(pol), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(sl), .smp_right_i(sr), .pdm_clk_o(pclk), .pdm_dat_o(pdat)
  );

  // stimulus driver: 0 constant, 1 other data off-request, 2 offer once then stop
  always @(negedge clk) begin
    case (mode)
      1: begin valid = 1'b1; sl = ready ? al : bl; sr = ready ? ar : br; end
      2: begin
        valid = !took; sl = took ? bl : al; sr = took ? br : ar;
        if (ready && !took) took = 1;
      end
      default: begin valid = 1'b1; sl = al; sr = ar; end
    endcase
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int expect_ones(input logic [23:0] x);
    real r;
    r = real'(WIN) * (real'($signed(x)) + 8388608.0) / 16777216.0;
    return int'(r);
  endfunction

  task automatic start(input logic [1:0] o, input logic [1:0] c, input logic p, input int m);
    @(negedge clk);
    en = 1'b0; osr = o; chs = c; pol = p; mode = m; took = 0;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
  endtask

  // counts ones in clock-high (first) and clock-low (second) halves
  task automatic collect(output int f1, output int f2, output int clk_bad);
    f1 = 0; f2 = 0; clk_bad = 0;
    for (int p = 0; p < WARM + WIN; p++) begin
      @(negedge clk); if (pclk !== 1'b1) clk_bad++; if (p >= WARM && pdat) f1++;
      @(negedge clk); if (pclk !== 1'b1) clk_bad++;
      @(negedge clk); if (pclk !== 1'b0) clk_bad++; if (p >= WARM && pdat) f2++;
      @(negedge clk); if (pclk !== 1'b0) clk_bad++;
    end
  endtask

  function automatic bit near(input int g, input int e);
    return (g - e <= 4) && (e - g <= 4);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int f1, f2, cb, gap;
    al = 24'sd2097152; ar = -24'sd4194304; bl = -24'sd6291456; br = 24'sd6291456;
    repeat (3) @(negedge clk);
    check(!pclk && !pdat && !ready, "R7 reset", {pclk, pdat, ready}, 0);
    rst_n = 1'b1;

    // R1: request spacing per oversampling code
    for (int c = 0; c < 4; c++) begin
      start(2'(c), 2'd3, 1'b0, 0);
      @(negedge clk);
      check(ready === 1'b1, "R1 first request", ready, 1);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!ready && gap < 5000);
      check(gap == (4 << (c + 5)), "R1 spacing", gap, 4 << (c + 5));
      stop();
    end

    // R3/R4/R2: stereo, left in clock-high half
    start(2'd0, 2'd3, 1'b0, 0);
    collect(f1, f2, cb);
    check(cb == 0, "R2 clock pattern", cb, 0);
    check(near(f1, expect_ones(al)), "R4 left slot", f1, expect_ones(al));
    check(near(f2, expect_ones(ar)), "R4 right slot", f2, expect_ones(ar));
    stop();

    // R5: swapped polarity
    start(2'd0, 2'd3, 1'b1, 0);
    collect(f1, f2, cb);
    check(near(f1, expect_ones(ar)), "R5 right in high half", f1, expect_ones(ar));
    check(near(f2, expect_ones(al)), "R5 left in low half", f2, expect_ones(al));
    stop();

    // R3: zero input and small positive, ratio 256
    al = 24'd0; ar = 24'sd838861;
    start(2'd3, 2'd3, 1'b0, 0);
    collect(f1, f2, cb);
    check(near(f1, expect_ones(al)), "R3 zero input", f1, expect_ones(al));
    check(near(f2, expect_ones(ar)), "R3 small positive", f2, expect_ones(ar));
    check(cb == 0, "R2 clock pattern ratio 256", cb, 0);
    stop();

    // R6: channel enables
    al = 24'sd4194304; ar = 24'sd4194304;
    start(2'd0, 2'd1, 1'b0, 0);
    collect(f1, f2, cb);
    check(near(f1, expect_ones(al)), "R6 left only active", f1, expect_ones(al));
    check(f2 == 0, "R6 left only muted right", f2, 0);
    stop();
    start(2'd0, 2'd2, 1'b0, 0);
    collect(f1, f2, cb);
    check(f1 == 0, "R6 right only muted left", f1, 0);
    check(near(f2, expect_ones(ar)), "R6 right only active", f2, expect_ones(ar));
    stop();
    start(2'd0, 2'd0, 1'b0, 0);
    collect(f1, f2, cb);
    check(f1 == 0 && f2 == 0, "R6 no channel", f1 + f2, 0);
    stop();

    // R8: data differs outside request cycles
    al = -24'sd2097152; ar = 24'sd3145728;
    start(2'd0, 2'd3, 1'b0, 1);
    collect(f1, f2, cb);
    check(near(f1, expect_ones(al)), "R8 left captured only on handshake", f1, expect_ones(al));
    check(near(f2, expect_ones(ar)), "R8 right captured only on handshake", f2, expect_ones(ar));
    stop();

    // R9: no valid after first request
    al = 24'sd1048576; ar = -24'sd1048576;
    start(2'd0, 2'd3, 1'b0, 2);
    collect(f1, f2, cb);
    check(near(f1, expect_ones(al)), "R9 left held", f1, expect_ones(al));
    check(near(f2, expect_ones(ar)), "R9 right held", f2, expect_ones(ar));
    stop();

    // R10: full-scale extremes
    al = 24'h7FFFFF; ar = 24'h800000;
    start(2'd0, 2'd3, 1'b0, 0);
    collect(f1, f2, cb);
    check(f1 == WIN, "R10 positive full scale", f1, WIN);
    check(f2 == 0, "R10 negative full scale", f2, 0);

    // R7: disable mid-run
    @(negedge clk); en = 1'b0;
    cb = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pclk || pdat || ready) cb++;
    end
    check(cb == 0, "R7 outputs quiet when disabled", cb, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule